// File: doc/BRIEF.md
# Serial Clock Divider with Indexed Ratios

This block derives a serial bit clock from the peripheral clock. The divisor is picked by a small index code rather than given as a raw count. One input selects between two ratio series. The table series mixes powers of two with three-times-powers-of-two: 3, 4, 6, 8, 12 and so on, up to 768 and 1024. The power-of-two series starts at 4 and doubles up to 512. The divider also produces a one-cycle strobe at each leading edge and each trailing edge of the serial clock, so that a shifter can launch and capture data without looking at the clock level.

The serial clock sits at the polarity level while idle. A clock period starts when the run input is high. A divisor N gives an active phase of floor(N/2) input cycles and an idle-level phase of the remaining cycles, so every period is exactly N cycles. The code, series and polarity are sampled only while the divider is idle. When run drops, the period in progress is completed and the clock then stops at the idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, sclk is 0 and both strobes are 0.
- R2: In table mode (mode_pow2=0), codes 2 to 16 give divisors 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512. Even code c gives 2^((c+2)/2) and odd code c gives 3*2^((c-1)/2).
- R3: In table mode, code 1 gives divide-by-3 only when allow_div3 is 1. Otherwise it gives the largest valid divisor.
- R4: In table mode, code 0 and any code above the highest valid code give the largest valid divisor.
- R5: In power-of-two mode (mode_pow2=1), code k for k from 0 to 7 gives divisor 4*2^k. Codes 8 and above give 512.
- R6: For divisor N, sclk holds the active level (the inverse of cpol) for floor(N/2) cycles in each period, and the idle level for N-floor(N/2) cycles.
- R7: While the divider is idle, sclk equals cpol, one cycle after cpol is applied.
- R8: lead_stb is high for one cycle, in the same cycle that sclk first shows the active level. trail_stb is high for one cycle, in the same cycle that sclk returns to the idle level. The two strobes are never high together.
- R9: A change of div_code or mode_pow2 while a period is running has no effect on the running divisor. The period length between consecutive leading edges stays at the value sampled at start.
- R10: When run is low at the end of a period, the divider finishes that period and gives no further leading edge. It shows exactly one trailing edge and ends at the idle level.
- R11: With EXT_TABLE=1, the highest valid table code is 18, and codes 17 and 18 give 768 and 1024. With EXT_TABLE=0, the highest code is 16 and the largest divisor is 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start periods and keep running while high |
| mode_pow2 | input | 1 | 0: mixed table series, 1: power-of-two series |
| div_code | input | CODE_W | Divisor index |
| allow_div3 | input | 1 | Permits table code 1 (divide by 3) |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe at the leading edge |
| trail_stb | output | 1 | One-cycle strobe at the trailing edge |

## Verification
The bench builds the block with EXT_TABLE=1 and CODE_W=5. This puts codes 17 and 18 (768 and 1024) within reach, and also out-of-range table codes from 19 to 31. The five-bit code width also drives power-of-two codes well beyond 7, so the fallback to 512 is exercised. The smallest odd divisor, 3, shows the floor split at its tightest: one active cycle and two idle-level cycles.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    typedef enum logic {
        SERIES_TABLE = 1'b0,
        SERIES_POW2  = 1'b1
    } series_e;

    localparam int BASE_TOP_CODE = 16;
    localparam int EXT_TOP_CODE  = 18;
    localparam int POW2_TOP_CODE = 7;

    function automatic int top_code(input bit ext);
        return ext ? EXT_TOP_CODE : BASE_TOP_CODE;
    endfunction

endpackage

// File: rtl/sclk_ratio_lookup.sv
module sclk_ratio_lookup
    import spi_sclk_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter int DIV_W     = 11,
    parameter bit EXT_TABLE = 1'b1
) (
    input  logic              mode_pow2,
    input  logic [CODE_W-1:0] div_code,
    input  logic              allow_div3,
    output logic [DIV_W-1:0]  ratio
);
    localparam int TOP_CODE = top_code(EXT_TABLE);
    localparam int MAX_DIV  = 1 << ((TOP_CODE + 2) / 2);
    localparam int POW2_MAX = 4 << POW2_TOP_CODE;

    series_e           series;
    logic [DIV_W-1:0]  tbl_ratio;
    logic [DIV_W-1:0]  pow_ratio;
    logic [CODE_W-1:0] code_m1;
    logic [CODE_W-1:0] code_p2;

    assign series  = series_e'(mode_pow2);
    assign code_m1 = div_code - CODE_W'(1);
    assign code_p2 = div_code + CODE_W'(2);

    always_comb begin
        if (div_code == '0 || div_code > CODE_W'(TOP_CODE) ||
            (div_code == CODE_W'(1) && !allow_div3)) begin
            tbl_ratio = DIV_W'(MAX_DIV);
        end else if (div_code[0]) begin
            tbl_ratio = DIV_W'(3) << (code_m1 >> 1);
        end else begin
            tbl_ratio = DIV_W'(1) << (code_p2 >> 1);
        end
    end

    always_comb begin
        if (div_code > CODE_W'(POW2_TOP_CODE)) begin
            pow_ratio = DIV_W'(POW2_MAX);
        end else begin
            pow_ratio = DIV_W'(4) << div_code[2:0];
        end
    end

    assign ratio = (series == SERIES_POW2) ? pow_ratio : tbl_ratio;

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic [DIV_W-1:0] ratio_in,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    typedef struct packed {
        logic             active;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        logic             pol;
        logic             sclk;
        logic             lead;
        logic             trail;
    } phase_t;

    phase_t st_d, st_q;

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] last_q;
    logic [DIV_W-1:0] cnt_inc;

    assign half_q  = st_q.ratio >> 1;
    assign last_q  = st_q.ratio - DIV_W'(1);
    assign cnt_inc = st_q.cnt + DIV_W'(1);

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!st_q.active) begin
            st_d.ratio = ratio_in;
            st_d.pol   = cpol;
            st_d.sclk  = cpol;
            st_d.cnt   = '0;
            if (run) begin
                st_d.active = 1'b1;
                st_d.sclk   = ~cpol;
                st_d.lead   = 1'b1;
            end
        end else if (st_q.cnt == last_q) begin
            st_d.cnt = '0;
            if (run) begin
                st_d.sclk = ~st_q.pol;
                st_d.lead = 1'b1;
            end else begin
                st_d.active = 1'b0;
                st_d.sclk   = st_q.pol;
            end
        end else begin
            st_d.cnt = cnt_inc;
            if (cnt_inc == half_q) begin
                st_d.sclk  = st_q.pol;
                st_d.trail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.cnt    <= '0;
            st_q.ratio  <= DIV_W'(4);
            st_q.pol    <= 1'b0;
            st_q.sclk   <= 1'b0;
            st_q.lead   <= 1'b0;
            st_q.trail  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk      = st_q.sclk;
    assign lead_stb  = st_q.lead;
    assign trail_stb = st_q.trail;

    a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    a_r8_lead_active_level: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != st_q.pol));

    a_r8_trail_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == st_q.pol));

    a_r7_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (!lead_stb && !trail_stb));

    a_r9_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active)) |-> $stable(st_q.ratio));

    a_r6_trail_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (st_q.cnt == half_q));

    a_r10_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_d.active) |-> (st_q.cnt == last_q && !run));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter bit EXT_TABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode_pow2,
    input  logic [CODE_W-1:0] div_code,
    input  logic              allow_div3,
    input  logic              cpol,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);
    localparam int TOP_CODE = top_code(EXT_TABLE);
    localparam int MAX_DIV  = 1 << ((TOP_CODE + 2) / 2);
    localparam int DIV_W    = $clog2(MAX_DIV) + 1;

    logic [DIV_W-1:0] ratio;

    sclk_ratio_lookup #(
        .CODE_W    (CODE_W),
        .DIV_W     (DIV_W),
        .EXT_TABLE (EXT_TABLE)
    ) i_lookup (
        .mode_pow2  (mode_pow2),
        .div_code   (div_code),
        .allow_div3 (allow_div3),
        .ratio      (ratio)
    );

    sclk_phase_gen #(
        .DIV_W (DIV_W)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (cpol),
        .ratio_in  (ratio),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sclk && !lead_stb && !trail_stb));

endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       mode_pow2 = 1'b0;
    logic [4:0] div_code = 5'd2;
    logic       allow_div3 = 1'b0;
    logic       cpol = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int nchk = 0;
    int nfail = 0;

    int tbl_ratio [0:18] = '{1024, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96,
                             128, 192, 256, 384, 512, 768, 1024};

    always #2 clk = ~clk;

    spi_sclk_gen #(.CODE_W(5), .EXT_TABLE(1'b1)) i_spi_sclk_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_pow2(mode_pow2),
        .div_code(div_code), .allow_div3(allow_div3), .cpol(cpol),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    function automatic int exp_ratio(input bit pw, input int code, input bit a3);
        if (pw) begin
            if (code > 7) return 512;
            return 4 * (1 << code);
        end
        if (code == 0 || code > 18) return 1024;
        if (code == 1 && !a3) return 1024;
        return tbl_ratio[code];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input bit pw, input int code, input bit a3,
                           input bit pol, input string req);
        int n, h, per, act, cyc, leads, trails;
        bit got;
        n = exp_ratio(pw, code, a3);
        @(negedge clk);
        run = 1'b0; mode_pow2 = pw; div_code = 5'(code);
        allow_div3 = a3; cpol = pol;
        repeat (3) @(negedge clk);
        check(sclk == pol, "R7 idle level", int'(sclk), int'(pol));
        run = 1'b1;
        got = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (lead_stb) begin got = 1'b1; break; end
        end
        check(got, "R8 lead strobe seen", int'(got), 1);
        check(sclk == !pol, "R8 lead aligned active level", int'(sclk), int'(!pol));
        div_code = 5'($urandom);
        mode_pow2 = 1'($urandom);
        h = -1; per = -1; act = 1; cyc = 0;
        while (per < 0 && cyc < 2100) begin
            @(negedge clk);
            cyc++;
            if (lead_stb) per = cyc;
            else begin
                if (sclk != pol) act++;
                if (trail_stb && h < 0) begin
                    h = cyc;
                    check(sclk == pol, "R8 trail aligned idle level", int'(sclk), int'(pol));
                end
            end
        end
        check(per == n, $sformatf("%s R9 period", req), per, n);
        check(h == n / 2, "R8 trail strobe timing", h, n / 2);
        check(act == n / 2, "R6 active phase length", act, n / 2);
        run = 1'b0;
        leads = 0; trails = 0;
        for (int i = 0; i < n + 4; i++) begin
            @(negedge clk);
            if (lead_stb) leads++;
            if (trail_stb) trails++;
        end
        check(leads == 0, "R10 no lead after stop", leads, 0);
        check(trails == 1, "R10 single trail after stop", trails, 1);
        check(sclk == pol, "R10 rest at idle level", int'(sclk), int'(pol));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
        check(!lead_stb && !trail_stb, "R1 reset strobes",
              int'(lead_stb) + int'(trail_stb), 0);
        rst_n = 1'b1;
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R7 follows cpol", int'(sclk), 1);

        measure(1'b0, 1, 1'b1, 1'b0, "R3 div3 allowed");
        measure(1'b0, 1, 1'b0, 1'b1, "R3 div3 blocked");
        for (int c = 2; c <= 16; c++)
            measure(1'b0, c, 1'b0, 1'(c), "R2 table code");
        measure(1'b0, 17, 1'b0, 1'b0, "R11 code17");
        measure(1'b0, 18, 1'b1, 1'b1, "R11 code18");
        measure(1'b0, 0, 1'b1, 1'b0, "R4 code0");
        measure(1'b0, 19, 1'b0, 1'b1, "R4 code19");
        measure(1'b0, 31, 1'b1, 1'b0, "R4 code31");
        for (int c = 0; c <= 9; c++)
            measure(1'b1, c, 1'b0, 1'(c >> 1), "R5 pow2 code");
        for (int i = 0; i < 25; i++) begin
            bit pw;
            int c;
            pw = 1'($urandom);
            c = pw ? int'($urandom % 12) : int'($urandom % 16);
            measure(pw, c, 1'($urandom), 1'($urandom), pw ? "R5 random" : "R2 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule